// File: doc/BRIEF.md
# Password Gated Access Controller

This block stands between a host and two memory arrays, a main array and an auxiliary array, and decides whether the host may read or write either one. The host talks to it over a byte-wide stream. It first sends a command byte that names the access it wants, then eight password bytes. When the password is right, the block raises a grant line for that access. The grant stays high until the host ends the session.

Every wrong or unfinished password entry adds one to a count of consecutive failures, and any correct password clears that count. When the count reaches its limit, the block wipes both arrays. It does this by driving write strobes for every address, with all-ones data, into a behavioural memory model. It then locks itself. While locked, the four access passwords are refused, and only the recovery password brings the block back to normal use. The password values are held in registers that are loaded at reset from a parameter.

Top module: `pw_gate`

## Requirements
- R1: After reset, grant_o is 0, busy_o is 0, locked_o is 0, and both erase strobes are 0.
- R2: A command byte arrives with cmd_valid_i high and selects the access by its value: 0 is main read, 1 is main write, 2 is aux read, 3 is aux write, 4 is recovery. A command byte above 4 is ignored.
- R3: The password is the eight data bytes that follow the command byte with byte_valid_i high, most significant byte first. If it matches the access password, grant_o bit <command value> is 1 from the cycle after the eighth byte. It stays 1 until end_i, and the cycle after end_i all grant bits are 0.
- R4: A password that does not match raises no grant and counts as one failed attempt.
- R5: A correct password sets the failure count back to zero, so seven failures, then a success, then seven more failures do not start an erase.
- R6: An entry that is cut short before its eighth byte, either by end_i or by a new valid command byte, counts as a failed attempt. A new command byte also starts a fresh entry.
- R7: The eighth consecutive failure starts an erase. From the next cycle, busy_o stays high for max(MAIN_DEPTH, AUX_DEPTH) cycles. During those cycles erase_addr_o steps 0, 1, 2 and so on, one step per cycle. main_we_o is high while the address is below MAIN_DEPTH, aux_we_o is high while it is below AUX_DEPTH, and erase_data_o is all ones. All grants drop when the erase starts.
- R8: While busy_o is high, commands, password bytes and end_i have no effect.
- R9: locked_o rises together with busy_o. While locked_o is high, even a correct access password raises no grant, and failed attempts are not counted.
- R10: A correct recovery password clears locked_o and the failure count, after which the access passwords work again. A wrong recovery password while locked has no effect.
- R11: Password bytes that arrive with no entry open, including bytes after an eighth byte, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | data_i carries a command byte |
| byte_valid_i | input | 1 | data_i carries a password byte |
| data_i | input | 8 | Command or password byte |
| end_i | input | 1 | Ends the session and aborts an open entry |
| grant_o | output | 4 | Grants: main rd, main wr, aux rd, aux wr (bits 0 to 3) |
| busy_o | output | 1 | Erase walk in progress |
| locked_o | output | 1 | Access passwords disabled until recovery |
| main_we_o | output | 1 | Erase write strobe to the main array |
| aux_we_o | output | 1 | Erase write strobe to the aux array |
| erase_addr_o | output | ADDR_W | Erase walk address |
| erase_data_o | output | DATA_W | Erase write data (all ones) |

## Verification
Each grant is due exactly one cycle after the edge that takes in the eighth password byte. A grant clear is due one cycle after end_i. The rise of busy_o and locked_o is due one cycle after the failing byte or abort, and each erase address follows one cycle after the one before it. The driver task works out, for the edge it drives, the full output state that should follow. It queues that state tagged with the number of the next cycle. The monitor samples on the falling edge and pops an entry only when its cycle number matches the current one, so every comparison falls on the exact cycle the result is due.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PW_BYTES = 8;
  localparam int PW_W     = 8 * PW_BYTES;
  localparam int N_ACCESS = 4;
  localparam int N_PW     = 5;

  typedef enum logic [2:0] {
    SEL_MAIN_RD = 3'd0,
    SEL_MAIN_WR = 3'd1,
    SEL_AUX_RD  = 3'd2,
    SEL_AUX_WR  = 3'd3,
    SEL_RECOVER = 3'd4
  } sel_e;
endpackage

// File: rtl/pw_collect.sv
module pw_collect #(
  parameter int BYTES = 8,
  localparam int W  = 8 * BYTES,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic         byte_valid_i,
  input  logic [7:0]   byte_i,
  output logic         active_o,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  word_q;
  logic          take;

  assign take     = active_q & byte_valid_i;
  assign word_o   = {word_q[W-9:0], byte_i};
  assign done_o   = take && (cnt_q == CW'(BYTES - 1));
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      word_q   <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      word_q   <= '0;
    end else if (take) begin
      word_q <= word_o;
      cnt_q  <= cnt_q + 1'b1;
      if (done_o) active_q <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> cnt_q < CW'(BYTES)) else $error("byte count overran entry"); // R3
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clear_i && !start_i |=> !active_o) else $error("entry stayed open"); // R11
endmodule

// File: rtl/pw_match.sv
module pw_match #(
  parameter int N = 5,
  parameter int W = 64,
  parameter logic [N*W-1:0] PW_INIT = '0,
  localparam int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  word_i,
  output logic          hit_o
);
  logic [W-1:0] pw_q [N];

  for (genvar g = 0; g < N; g++) begin : g_pw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pw_q[g] <= PW_INIT[g*W +: W];
      else         pw_q[g] <= pw_q[g];
    end
  end

  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < N; i++)
      if (sel_i == SW'(i) && word_i == pw_q[i]) hit_o = 1'b1;
  end
endmodule

// File: rtl/erase_walk.sv
module erase_walk #(
  parameter int MAIN_DEPTH = 64,
  parameter int AUX_DEPTH  = 16,
  parameter int ADDR_W     = 6,
  localparam int WALK = (MAIN_DEPTH > AUX_DEPTH) ? MAIN_DEPTH : AUX_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              main_we_o,
  output logic              aux_we_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else if (busy_q) begin
      if (addr_q == ADDR_W'(WALK - 1)) begin
        busy_q <= 1'b0;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      addr_q <= '0;
    end
  end

  assign busy_o    = busy_q;
  assign addr_o    = addr_q;
  assign main_we_o = busy_q && (32'(addr_q) < MAIN_DEPTH);
  assign aux_we_o  = busy_q && (32'(addr_q) < AUX_DEPTH);

  AST_WALK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> addr_o == $past(addr_o) + 1'b1) else $error("walk skipped"); // R7
  AST_WALK_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> addr_o == '0) else $error("walk not from zero"); // R7
endmodule

// File: rtl/pw_gate.sv
module pw_gate
  import pw_pkg::*;
#(
  parameter int MAIN_DEPTH = 64,
  parameter int AUX_DEPTH  = 16,
  parameter int MAX_FAILS  = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = $clog2((MAIN_DEPTH > AUX_DEPTH) ? MAIN_DEPTH : AUX_DEPTH),
  parameter logic [N_PW*PW_W-1:0] PW_INIT = {
    64'h5EC0_7E57_0BAD_F00D, 64'hA5A5_0000_FFFF_1234, 64'h0F0F_3C3C_9696_C3C3,
    64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        data_i,
  input  logic              end_i,
  output logic [3:0]        grant_o,
  output logic              busy_o,
  output logic              locked_o,
  output logic              main_we_o,
  output logic              aux_we_o,
  output logic [ADDR_W-1:0] erase_addr_o,
  output logic [DATA_W-1:0] erase_data_o
);
  localparam int FW = $clog2(MAX_FAILS + 1);

  logic            cmd_ok, end_ok, byte_ok, abort, active, done, hit;
  logic            is_rec, fail_ev, rec_ok, grant_set, erase_start;
  logic [PW_W-1:0] word;
  sel_e            sel_q;
  logic [FW-1:0]   fail_q;
  logic            locked_q;
  logic [3:0]      grant_q;

  assign end_ok  = end_i & ~busy_o;
  assign cmd_ok  = cmd_valid_i & ~end_i & ~busy_o & (data_i <= 8'(SEL_RECOVER));
  assign byte_ok = byte_valid_i & ~cmd_valid_i & ~end_i & ~busy_o;
  assign abort   = active & (cmd_ok | end_ok);

  pw_collect #(.BYTES(PW_BYTES)) u_collect (
    .clk_i, .rst_ni,
    .clear_i(erase_start | end_ok), .start_i(cmd_ok),
    .byte_valid_i(byte_ok), .byte_i(data_i),
    .active_o(active), .done_o(done), .word_o(word)
  );

  pw_match #(.N(N_PW), .W(PW_W), .PW_INIT(PW_INIT)) u_match (
    .clk_i, .rst_ni, .sel_i(sel_q), .word_i(word), .hit_o(hit)
  );

  erase_walk #(.MAIN_DEPTH(MAIN_DEPTH), .AUX_DEPTH(AUX_DEPTH), .ADDR_W(ADDR_W)) u_walk (
    .clk_i, .rst_ni, .start_i(erase_start), .busy_o(busy_o),
    .addr_o(erase_addr_o), .main_we_o(main_we_o), .aux_we_o(aux_we_o)
  );

  assign is_rec      = (sel_q == SEL_RECOVER);
  assign rec_ok      = done & is_rec & hit;
  assign grant_set   = done & ~is_rec & hit & ~locked_q;
  // locked: neither aborts nor misses are counted
  assign fail_ev     = ~locked_q & (abort | (done & ~hit));
  assign erase_start = fail_ev && (fail_q == FW'(MAX_FAILS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_MAIN_RD;
      fail_q   <= '0;
      locked_q <= 1'b0;
      grant_q  <= '0;
    end else begin
      if (cmd_ok) sel_q <= sel_e'(data_i[2:0]);
      if (erase_start) begin
        fail_q   <= '0;
        locked_q <= 1'b1;
        grant_q  <= '0;
      end else begin
        if (rec_ok) begin
          fail_q   <= '0;
          locked_q <= 1'b0;
        end else if (grant_set) begin
          fail_q            <= '0;
          grant_q[sel_q[1:0]] <= 1'b1;
        end else if (fail_ev) begin
          fail_q <= fail_q + 1'b1;
        end
        if (end_ok) grant_q <= '0;
      end
    end
  end

  assign grant_o      = grant_q;
  assign locked_o     = locked_q;
  assign erase_data_o = '1;

  AST_NO_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> grant_o == '0) else $error("grant while erasing"); // R8
  AST_LOCK_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> grant_o == '0) else $error("grant while locked"); // R9
  AST_FAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q < FW'(MAX_FAILS)) else $error("fail count overflow"); // R5
  AST_ERASE_ON_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start |=> busy_o && locked_o) else $error("limit without erase"); // R7
  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_ok |=> grant_o == '0) else $error("end left a grant"); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(locked_o)) else $error("lock moved while busy"); // R8
endmodule

// File: tb/pw_gate_test.sv
module pw_gate_test;
  localparam int MAIN_D = 64;
  localparam int AUX_D  = 16;
  localparam int WALK   = 64;
  localparam logic [63:0] PW [5] = '{
    64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_3C3C_9696_C3C3,
    64'hA5A5_0000_FFFF_1234, 64'h5EC0_7E57_0BAD_F00D};
  localparam logic [63:0] BAD = 64'hDEAD_BEEF_DEAD_BEEF;

  typedef struct {
    int         cyc;
    logic [3:0] g;
    logic       bz, lk, mw, aw;
    logic [5:0] ad;
    string      req;
  } item_t;

  logic       clk = 0, rst_n = 0;
  logic       cmd_v = 0, byte_v = 0, end_v = 0;
  logic [7:0] data = '0;
  logic [3:0] grant;
  logic       busy, locked, mwe, awe;
  logic [5:0] addr;
  logic [7:0] edata;

  int cyc_n = 0, checks = 0, errs = 0;
  bit done_flag = 0;
  item_t q[$];

  // bench-side expected state
  logic [3:0] m_grant = '0;
  bit m_locked = 0, m_walk = 0, m_entry = 0;
  int m_pos = 0, m_fails = 0, m_cnt = 0, m_sel = 0;
  logic [63:0] m_word = '0;

  pw_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_v), .byte_valid_i(byte_v),
    .data_i(data), .end_i(end_v), .grant_o(grant), .busy_o(busy), .locked_o(locked),
    .main_we_o(mwe), .aux_we_o(awe), .erase_addr_o(addr), .erase_data_o(edata));

  always #4 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  task automatic fail_attempt();
    if (m_locked) return;
    m_fails++;
    if (m_fails == 8) begin
      m_fails = 0; m_locked = 1; m_grant = '0;
      m_walk = 1; m_pos = 0; m_entry = 0;
    end
  endtask

  task automatic cyc(input bit c, input bit b, input bit e, input logic [7:0] d, input string req);
    item_t it;
    @(posedge clk); #1;
    cmd_v = c; byte_v = b; end_v = e; data = d;
    if (m_walk) begin
      if (m_pos == WALK - 1) begin m_walk = 0; m_pos = 0; end
      else m_pos++;
    end else if (e) begin
      m_grant = '0;
      if (m_entry) begin m_entry = 0; fail_attempt(); end
    end else if (c) begin
      if (d <= 4) begin
        if (m_entry) fail_attempt();
        if (!m_walk) begin m_entry = 1; m_sel = d; m_cnt = 0; m_word = '0; end
      end
    end else if (b && m_entry) begin
      m_word = {m_word[55:0], d};
      m_cnt++;
      if (m_cnt == 8) begin
        m_entry = 0;
        if (m_sel == 4) begin
          if (m_word == PW[4]) begin m_locked = 0; m_fails = 0; end
          else fail_attempt();
        end else if (m_word == PW[m_sel]) begin
          if (!m_locked) begin m_grant[m_sel] = 1'b1; m_fails = 0; end
        end else fail_attempt();
      end
    end
    it.cyc = cyc_n + 1; it.g = m_grant; it.bz = m_walk; it.lk = m_locked;
    it.mw = m_walk && m_pos < MAIN_D; it.aw = m_walk && m_pos < AUX_D;
    it.ad = 6'(m_pos); it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, req);
  endtask

  task automatic send_pw(input logic [7:0] code, input logic [63:0] pw, input int nbytes, input string req);
    cyc(1, 0, 0, code, req);
    for (int i = 0; i < nbytes; i++) cyc(0, 1, 0, pw[63-8*i -: 8], req);
  endtask

  // monitor: compare on the falling edge of the cycle an item is due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc == cyc_n) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (grant !== it.g || busy !== it.bz || locked !== it.lk || mwe !== it.mw ||
          awe !== it.aw || (it.bz && addr !== it.ad) || (it.bz && edata !== 8'hFF)) begin
        errs++;
        $display("FAIL %s cyc %0d: got g=%h bz=%b lk=%b mw=%b aw=%b ad=%0d exp g=%h bz=%b lk=%b mw=%b aw=%b ad=%0d",
                 it.req, cyc_n, grant, busy, locked, mwe, awe, addr,
                 it.g, it.bz, it.lk, it.mw, it.aw, it.ad);
      end
    end
  end

  initial begin
    #100000;
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(3, "R1 reset");
    // R2 R3: main read grant, R11: extra byte ignored
    send_pw(8'd0, PW[0], 8, "R3 main rd grant");
    cyc(0, 1, 0, 8'h55, "R11 stray byte");
    send_pw(8'd3, PW[3], 8, "R2 aux wr grant");
    cyc(0, 0, 1, 8'h00, "R3 end clears");
    idle(1, "R3 after end");
    // R2: invalid code ignored
    send_pw(8'd5, PW[0], 8, "R2 bad code ignored");
    idle(1, "R2 no grant");
    // R4 wrong password
    send_pw(8'd3, BAD, 8, "R4 wrong pw");
    // R6 aborts: by end and by new command
    send_pw(8'd1, PW[1], 3, "R6 abort by end");
    cyc(0, 0, 1, 8'h00, "R6 end abort");
    send_pw(8'd2, PW[2], 5, "R6 abort by cmd");
    for (int k = 0; k < 4; k++) send_pw(8'd1, BAD, 8, "R4 wrong pw run");
    // 7 failures so far; success resets count (R5)
    send_pw(8'd2, PW[2], 8, "R5 aux rd resets count");
    cyc(0, 0, 1, 8'h00, "R3 end");
    for (int k = 0; k < 7; k++) send_pw(8'd0, BAD, 8, "R5 seven fails no erase");
    idle(2, "R5 still idle");
    // eighth failure -> erase (R7), stimulus during walk ignored (R8)
    send_pw(8'd4, BAD, 8, "R7 eighth fail");
    send_pw(8'd0, PW[0], 8, "R8 ignored while busy");
    cyc(0, 0, 1, 8'h00, "R8 end ignored");
    idle(WALK - 6, "R7 walk");
    // R9 locked: correct access refused, misses not counted
    send_pw(8'd1, PW[1], 8, "R9 locked refuse");
    for (int k = 0; k < 9; k++) send_pw(8'd0, BAD, 8, "R9 not counted");
    // R10 wrong recovery no effect, then correct recovery
    send_pw(8'd4, BAD, 8, "R10 wrong recovery");
    send_pw(8'd4, PW[4], 8, "R10 recovery");
    send_pw(8'd1, PW[1], 8, "R10 access works");
    cyc(0, 0, 1, 8'h00, "R3 end");
    idle(3, "R10 tail");
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule